// File: doc/BRIEF.md
# Fixed-Point Mean Engine

This block computes the arithmetic mean of a list of unsigned 8.8 fixed-point values held in a byte-wide, single-port data memory. It first reads a count byte, then reads the operands two bytes at a time (integer byte, then fraction byte). It adds them into a wide accumulator, divides the sum by the count with a sequential restoring divider, and writes the 8.8 result into the two bytes that follow the operand array.

A falling edge on `start` launches a run. Holding `start` at either level does nothing. When the result is in memory, `done` rises for two cycles and the engine waits for the next falling edge. The memory has a registered read: data for an address driven in one cycle appears on `mem_rdata` in the next cycle.

Because the operands are already scaled by 256, the integer quotient of sum divided by count is the 8.8 mean. No extra scaling step is needed.

Top module: `mean_engine`

## Requirements
- R1: While reset is held and right after it is released, `done` and `mem_we` are low.
- R2: A run starts only when `start` goes from 1 to 0. Holding `start` low or high without that edge causes no memory write and no `done`.
- R3: The count N is read from byte address 0. A count byte of 0x00 means N = 256.
- R4: Operand k (k = 1..N) is the 16-bit value whose high (integer) byte is at address 2k-1 and whose low (fraction) byte is at address 2k. Input bytes are never overwritten.
- R5: The result is floor(sum of operands / N), taken as a 16-bit 8.8 value. Fractions below 1/256 are truncated. For example, operands 0x0024 and 0x0900 give 0x0492.
- R6: Each run makes exactly two memory writes. The integer byte of the result goes to address 2N+1, then the fraction byte goes to address 2N+2. No other address is written.
- R7: After the second result write, `done` is high for exactly two consecutive cycles and then low.
- R8: With N = 256 and every operand 0xFFFF, the sum does not overflow. The result is 0xFFFF, written at addresses 513 and 514.
- R9: A new falling edge on `start` after `done` runs the engine again on the current memory contents, with no reset in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request; a run begins on its falling edge |
| mem_addr | output | ADDR_W (10) | Byte address to the data memory |
| mem_rdata | input | DATA_W (8) | Read data, valid one cycle after the address |
| mem_wdata | output | DATA_W (8) | Write data |
| mem_we | output | 1 | Write enable for the current address |
| done | output | 1 | High for two cycles when a run completes |

## Verification
The bench builds the engine with its default parameters: 8-bit count, 8-bit data and a 10-bit address. With these, the largest case is within reach: a count byte of zero read as 256 operands, a 24-bit sum of all-ones values, and result writes at addresses 513 and 514. The directed cases cover the smallest count (N = 1), a sum that does not divide evenly so that truncation shows, a mixed 256-entry ramp, and repeated launches without reset. Sentinel bytes around the result location show any stray write.

// File: rtl/mean_pkg.sv
package mean_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CNT_REQ,
        ST_CNT_CAP,
        ST_HI_REQ,
        ST_HI_CAP,
        ST_LO_REQ,
        ST_LO_CAP,
        ST_DIV_GO,
        ST_DIV_WAIT,
        ST_WR_HI,
        ST_WR_LO,
        ST_FIN
    } mean_state_e;

endpackage

// File: rtl/mean_handshake.sv
module mean_handshake #(
    parameter int DONE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic armed,
    input  logic fin,
    output logic launch,
    output logic done
);
    localparam int CW = $clog2(DONE_CYC + 1);

    typedef struct packed {
        logic          start_seen;
        logic [CW-1:0] hold;
    } hs_t;

    hs_t cur_q, nxt_d;

    always_comb begin
        nxt_d            = cur_q;
        nxt_d.start_seen = start;
        if (fin) begin
            nxt_d.hold = CW'(DONE_CYC);
        end else if (cur_q.hold != '0) begin
            nxt_d.hold = cur_q.hold - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign launch = armed && cur_q.start_seen && !start;
    assign done   = (cur_q.hold != '0);

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |=> done); // R7
    AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done) && !fin) |=> !done); // R7

endmodule

// File: rtl/mean_divider.sv
module mean_divider #(
    parameter int DVD_W = 24,
    parameter int DVS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             valid,
    output logic [DVD_W-1:0] quotient
);
    localparam int IW = $clog2(DVD_W + 1);

    typedef struct packed {
        logic             busy;
        logic             fin;
        logic [IW-1:0]    step;
        logic [DVS_W-1:0] rem;
        logic [DVD_W-1:0] quo;
        logic [DVS_W-1:0] dvs;
    } div_t;

    div_t cur_q, nxt_d;
    logic [DVS_W:0] trial;
    logic [DVS_W:0] diff;
    logic           fits;

    always_comb begin
        trial = {cur_q.rem, cur_q.quo[DVD_W-1]};
        diff  = trial - {1'b0, cur_q.dvs};
        fits  = (trial >= {1'b0, cur_q.dvs});
    end

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.fin = 1'b0;
        if (go) begin
            nxt_d.busy = 1'b1;
            nxt_d.step = '0;
            nxt_d.rem  = '0;
            nxt_d.quo  = dividend;
            nxt_d.dvs  = divisor;
        end else if (cur_q.busy) begin
            nxt_d.rem  = fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
            nxt_d.quo  = {cur_q.quo[DVD_W-2:0], fits};
            nxt_d.step = cur_q.step + IW'(1);
            if (cur_q.step == IW'(DVD_W - 1)) begin
                nxt_d.busy = 1'b0;
                nxt_d.fin  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign valid    = cur_q.fin;
    assign quotient = cur_q.quo;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (cur_q.rem < cur_q.dvs)); // R5
    AST_DIVISOR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (divisor != '0)); // R3

endmodule

// File: rtl/mean_engine.sv
module mean_engine
    import mean_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 8,
    parameter int ADDR_W   = 10,
    parameter int DONE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              done
);
    localparam int VAL_W = 2 * DATA_W;
    localparam int SUM_W = VAL_W + CNT_W;
    localparam int NUM_W = CNT_W + 1;

    typedef struct packed {
        mean_state_e       state;
        logic [ADDR_W-1:0] ptr;
        logic [NUM_W-1:0]  num;
        logic [NUM_W-1:0]  left;
        logic [DATA_W-1:0] hi;
        logic [SUM_W-1:0]  sum;
        logic [VAL_W-1:0]  res;
    } eng_t;

    eng_t cur_q, nxt_d;

    logic             launch;
    logic             fin;
    logic             div_go;
    logic             div_valid;
    logic [SUM_W-1:0] div_quo;
    logic [NUM_W-1:0] num_rd;
    logic [ADDR_W-1:0] res_base;

    mean_handshake #(.DONE_CYC(DONE_CYC)) u_hs (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .armed  (cur_q.state == ST_IDLE),
        .fin    (fin),
        .launch (launch),
        .done   (done)
    );

    mean_divider #(.DVD_W(SUM_W), .DVS_W(NUM_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (cur_q.sum),
        .divisor  (cur_q.num),
        .valid    (div_valid),
        .quotient (div_quo)
    );

    always_comb begin
        num_rd = (mem_rdata == '0) ? {1'b1, {CNT_W{1'b0}}} : NUM_W'(mem_rdata);
    end

    always_comb begin
        nxt_d     = cur_q;
        div_go    = 1'b0;
        fin       = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        case (cur_q.state)
            ST_IDLE: begin
                if (launch) begin
                    nxt_d.ptr   = '0;
                    nxt_d.state = ST_CNT_REQ;
                end
            end
            ST_CNT_REQ: nxt_d.state = ST_CNT_CAP;
            ST_CNT_CAP: begin
                nxt_d.num   = num_rd;
                nxt_d.left  = num_rd;
                nxt_d.sum   = '0;
                nxt_d.ptr   = ADDR_W'(1);
                nxt_d.state = ST_HI_REQ;
            end
            ST_HI_REQ: nxt_d.state = ST_HI_CAP;
            ST_HI_CAP: begin
                nxt_d.hi    = mem_rdata;
                nxt_d.ptr   = cur_q.ptr + ADDR_W'(1);
                nxt_d.state = ST_LO_REQ;
            end
            ST_LO_REQ: nxt_d.state = ST_LO_CAP;
            ST_LO_CAP: begin
                nxt_d.sum  = cur_q.sum + SUM_W'({cur_q.hi, mem_rdata});
                nxt_d.ptr  = cur_q.ptr + ADDR_W'(1);
                nxt_d.left = cur_q.left - NUM_W'(1);
                nxt_d.state = (cur_q.left == NUM_W'(1)) ? ST_DIV_GO : ST_HI_REQ;
            end
            ST_DIV_GO: begin
                div_go      = 1'b1;
                nxt_d.state = ST_DIV_WAIT;
            end
            ST_DIV_WAIT: begin
                if (div_valid) begin
                    if (div_quo[SUM_W-1:VAL_W] != '0) begin
                        nxt_d.res = '1;
                    end else begin
                        nxt_d.res = div_quo[VAL_W-1:0];
                    end
                    nxt_d.state = ST_WR_HI;
                end
            end
            ST_WR_HI: begin
                mem_we      = 1'b1;
                mem_wdata   = cur_q.res[VAL_W-1:DATA_W];
                nxt_d.ptr   = cur_q.ptr + ADDR_W'(1);
                nxt_d.state = ST_WR_LO;
            end
            ST_WR_LO: begin
                mem_we      = 1'b1;
                mem_wdata   = cur_q.res[DATA_W-1:0];
                nxt_d.state = ST_FIN;
            end
            ST_FIN: begin
                fin         = 1'b1;
                nxt_d.state = ST_IDLE;
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mem_addr = cur_q.ptr;

    // result location derived from the count alone, independent of the pointer walk
    assign res_base = ADDR_W'({cur_q.num, 1'b1});

    AST_WR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == res_base || mem_addr == res_base + ADDR_W'(1))); // R6
    AST_WR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr == res_base) |=> (mem_we && mem_addr == res_base + ADDR_W'(1))); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_LO_CAP) |->
            !(({1'b0, cur_q.sum} + (SUM_W + 1)'({cur_q.hi, mem_rdata})) >> SUM_W)); // R8
    AST_QUOT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        div_valid |-> (div_quo[SUM_W-1:VAL_W] == '0)); // R5
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_IDLE) |-> !mem_we); // R2

endmodule

// File: tb/sim_mean_engine.sv
module sim_mean_engine;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata = '0;
    logic [7:0]    mem_wdata;
    logic          mem_we;
    logic          done;

    logic [7:0] mem [0:(1<<AW)-1];
    int         vals [0:255];
    int         wr_cnt = 0;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    mean_engine u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .done      (done)
    );

    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr];
        if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_case(input string name, input int n);
        int sum;
        int exp;
        int base;
        int width;
        int waited;
        int in1;
        sum = 0;
        for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h5A;
        mem[0] = 8'(n % 256);
        for (int k = 1; k <= n; k++) begin
            mem[2*k-1] = 8'(vals[k-1] >> 8);
            mem[2*k]   = 8'(vals[k-1]);
            sum += vals[k-1];
        end
        exp  = sum / n;
        if (exp > 65535) exp = 65535;
        base = 2*n + 1;
        mem[base] = 8'hA5; mem[base+1] = 8'hA5; mem[base+2] = 8'hA5;
        in1 = mem[1];
        @(negedge clk); start = 1'b1;
        repeat (3) @(negedge clk);
        wr_cnt = 0;
        start = 1'b0;
        waited = 0;
        while (!done && waited < 5000) begin
            @(negedge clk); waited++;
        end
        check(done, {name, " R7 done seen"}, done, 1);
        width = 0;
        while (done && width < 10) begin
            width++; @(negedge clk);
        end
        check(width == 2, {name, " R7 done width"}, width, 2);
        check(mem[base] == 8'(exp >> 8), {name, " R5 R6 int byte"}, mem[base], exp >> 8);
        check(mem[base+1] == 8'(exp), {name, " R5 R6 frac byte"}, mem[base+1], exp & 255);
        check(wr_cnt == 2, {name, " R6 write count"}, wr_cnt, 2);
        check(mem[base+2] == 8'hA5, {name, " R6 guard byte"}, mem[base+2], 8'hA5);
        check(mem[1] == 8'(in1), {name, " R4 input kept"}, mem[1], in1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!done, "R1 done in reset", done, 0);
        check(!mem_we, "R1 we in reset", mem_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !mem_we, "R1 after reset", {done, mem_we}, 0);
    endtask

    task automatic t_no_launch();
        int acts;
        acts = 0;
        wr_cnt = 0;
        repeat (40) begin @(negedge clk); if (done) acts++; end
        start = 1'b1;
        repeat (60) begin @(negedge clk); if (done) acts++; end
        check(acts == 0 && wr_cnt == 0, "R2 level holds no run", acts + wr_cnt, 0);
    endtask

    task automatic t_example();
        vals[0] = 16'h0024; vals[1] = 16'h0900;
        run_case("R5 example", 2);
        check(mem[5] == 8'h04 && mem[6] == 8'h92, "R5 example literal", {mem[5], mem[6]}, 16'h0492);
    endtask

    task automatic t_single();
        vals[0] = 16'h3A7C;
        run_case("R4 single", 1);
    endtask

    task automatic t_trunc();
        vals[0] = 16'h0100; vals[1] = 16'h0100; vals[2] = 16'h0200;
        run_case("R5 truncate", 3);
        check(mem[8] == 8'h55, "R5 truncated frac", mem[8], 8'h55);
    endtask

    task automatic t_full();
        for (int i = 0; i < 256; i++) vals[i] = 16'hFFFF;
        run_case("R8 full", 256);
        check(mem[513] == 8'hFF && mem[514] == 8'hFF, "R8 R3 max at 513/514", {mem[513], mem[514]}, 16'hFFFF);
    endtask

    task automatic t_ramp();
        for (int i = 0; i < 256; i++) vals[i] = (i * 257 + 13) & 16'hFFFF;
        run_case("R3 ramp 256", 256);
    endtask

    task automatic t_repeat();
        vals[0] = 16'h1000; vals[1] = 16'h2080; vals[2] = 16'h0001; vals[3] = 16'hFF00;
        run_case("R9 first", 4);
        vals[0] = 16'h0203; vals[1] = 16'h0405;
        run_case("R9 second", 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        t_no_launch();
        t_example();
        t_single();
        t_trunc();
        t_full();
        t_ramp();
        t_repeat();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule